// File: doc/BRIEF.md
# Dual-mode truth-table / counter-delay logic cell

This cell is a small piece of configurable logic. It runs either as a 4-input truth-table function or as an 8-bit counter and edge-delay engine. The mode comes from a static configuration code. That code is captured only while the synchronous reset is high, so the cell never changes personality in mid-operation.

In truth-table mode, a 16-bit configuration word holds one output bit for each input combination. The output follows the inputs combinationally.

In counter/delay mode the cell uses two of its inputs:

- `cell_in[0]` is the count clock. Every system-clock cycle in which it is high counts as one count-clock cycle, called a tick below.
- `cell_in[1]` is the clear input in counter mode and the delayed signal in delay mode.

In counter mode the cell emits one-cycle pulses each time the count reaches the configured limit. It also pulses when the clear input rises. In delay mode it holds back the selected edges of its delayed input by a programmable number of ticks.

Top module: `lut_cnt_cell`

## Requirements
- R1: When the latched function is truth-table, `cell_out` equals bit `cfg_lut[{cell_in[3],cell_in[2],cell_in[1],cell_in[0]}]`, with `cell_in[3]` as the most significant index bit. The output follows input changes with no clock involved.
- R2: Any 4-input function is realizable. With `cfg_lut` = 0x8000 the cell is an AND, with 0x7FFF a NAND, with 0xFFFE an OR and with 0x0001 a NOR. With 0x6996 it is an XOR, with 0x9669 an XNOR, and with 0x5555 it inverts `cell_in[0]`.
- R3: `cfg_func` is sampled only in cycles where `rst` is high. The codes are 00 and 11 for truth-table, 01 for counter and 10 for delay. A change of `cfg_func` while `rst` is low has no effect on the behaviour.
- R4: In counter mode a tick while the count equals `cfg_val` wraps the count to zero and raises `cell_out` for exactly the next cycle. Any other tick increments the count. Starting from a cleared count, pulses therefore follow every (`cfg_val`+1)-th tick, and a cycle without a tick does not advance the count.
- R5: In counter mode, `cell_in[1]` high clears the count and ticks are ignored. A cycle in which `cell_in[1]` is high after being low gives a one-cycle pulse on `cell_out` in the next cycle. Holding `cell_in[1]` high gives no further pulses.
- R6: In delay mode a selected edge of `cell_in[1]` reaches `cell_out` in the cycle after the (`cfg_val`+1)-th consecutive tick that sees `cell_in[1]` differing from `cell_out`.
- R7: In delay mode, if `cell_in[1]` is back at the level of `cell_out` at a tick before the delay has expired, the pending edge is dropped. `cell_out` does not change, and the next edge starts a fresh delay.
- R8: `cfg_edge` chooses which edges are delayed: 01 rising only, 10 falling only, 11 both, 00 none. An edge that is not chosen reaches `cell_out` in the cycle after the next tick.
- R9: In delay mode `cell_out` changes only in the cycle after a tick. Cycles without a tick neither move the output nor advance a pending delay.
- R10: In counter and delay mode `cell_out` is 0 during reset and stays 0 after reset until a pulse or a delayed edge is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; function code is captured while high |
| cfg_func | input | 2 | Function code: 00/11 truth-table, 01 counter, 10 delay |
| cfg_edge | input | 2 | Delayed-edge select: 01 rising, 10 falling, 11 both, 00 none |
| cfg_val | input | CNT_W (8) | Counter limit / delay length minus one |
| cfg_lut | input | 2**LUT_K (16) | Truth-table word, one bit per input combination |
| cell_in | input | LUT_K (4) | Cell inputs; bit 0 is the tick, bit 1 is the clear/delayed input |
| cell_out | output | 1 | Cell output |

## Verification
The bench builds the cell with its default parameters, LUT_K=4 and CNT_W=8. This gives the full 16-row truth table, and the whole table is reachable from a short vector list of standard and arbitrary functions. The 8-bit limit is run at the small values 0, 2 and 3. With these values the wrap, the period of every tick, a back-to-back delay, and a cancelled delay with restart all fall within a few dozen cycles. Gaps without ticks and live changes of the edge select are mixed in, to separate tick counting from cycle counting.

// File: rtl/cell_pkg.sv
package cell_pkg;

    typedef enum logic [1:0] {
        FN_LUT   = 2'b00,
        FN_COUNT = 2'b01,
        FN_DELAY = 2'b10
    } cell_fn_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // Map a raw function code to the internal function; 11 aliases to LUT.
    function automatic cell_fn_e decode_fn(input logic [1:0] code);
        cell_fn_e f;
        case (code)
            2'b01:   f = FN_COUNT;
            2'b10:   f = FN_DELAY;
            default: f = FN_LUT;
        endcase
        return f;
    endfunction

    // True when a transition toward new_lvl must wait out the delay.
    function automatic logic edge_held(input edge_sel_e sel, input logic new_lvl);
        logic [1:0] s;
        s = sel;
        return new_lvl ? s[0] : s[1];
    endfunction

endpackage

// File: rtl/cell_lut.sv
module cell_lut #(
    parameter int K = 4,
    localparam int ROWS = 2 ** K
) (
    input  logic [ROWS-1:0] table_bits,
    input  logic [K-1:0]    sel,
    output logic            y
);
    logic [ROWS-1:0] work;

    // Halve the candidate set once per select bit, LSB first.
    always_comb begin
        work = table_bits;
        for (int d = 0; d < K; d++) begin
            for (int m = 0; m < ROWS / 2; m++) begin
                if (m < (ROWS >> (d + 1))) begin
                    work[m] = sel[d] ? work[2*m+1] : work[2*m];
                end
            end
        end
        y = work[0];
    end
endmodule

// File: rtl/cell_counter.sv
module cell_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         pulse
);
    logic [W-1:0] count_q;
    logic         clr_q;
    logic         pulse_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
            clr_q   <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            clr_q <= clr;
            if (clr) begin
                count_q <= '0;
                pulse_q <= !clr_q;
            end else if (tick) begin
                if (count_q == limit) begin
                    count_q <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    count_q <= count_q + 1'b1;
                    pulse_q <= 1'b0;
                end
            end else begin
                pulse_q <= 1'b0;
            end
        end
    end

    assign pulse = pulse_q;
endmodule

// File: rtl/cell_delay.sv
module cell_delay
    import cell_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic         din,
    input  edge_sel_e    sel,
    input  logic [W-1:0] limit,
    output logic         dout
);
    logic         level_q;
    logic [W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            level_q <= 1'b0;
            wait_q  <= '0;
        end else if (tick) begin
            if (din == level_q) begin
                wait_q <= '0;
            end else if (!edge_held(sel, din)) begin
                level_q <= din;
                wait_q  <= '0;
            end else if (wait_q == limit) begin
                level_q <= din;
                wait_q  <= '0;
            end else begin
                wait_q <= wait_q + 1'b1;
            end
        end
    end

    assign dout = level_q;
endmodule

// File: rtl/lut_cnt_cell.sv
module lut_cnt_cell
    import cell_pkg::*;
#(
    parameter int LUT_K = 4,
    parameter int CNT_W = 8,
    localparam int ROWS = 2 ** LUT_K
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_func,
    input  logic [1:0]       cfg_edge,
    input  logic [CNT_W-1:0] cfg_val,
    input  logic [ROWS-1:0]  cfg_lut,
    input  logic [LUT_K-1:0] cell_in,
    output logic             cell_out
);
    cell_fn_e mode_q;
    logic     lut_y;
    logic     cnt_y;
    logic     dly_y;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= decode_fn(cfg_func);
        end
    end

    cell_lut #(.K(LUT_K)) u_lut (
        .table_bits(cfg_lut),
        .sel       (cell_in),
        .y         (lut_y)
    );

    cell_counter #(.W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .run  (mode_q == FN_COUNT),
        .tick (cell_in[0]),
        .clr  (cell_in[1]),
        .limit(cfg_val),
        .pulse(cnt_y)
    );

    cell_delay #(.W(CNT_W)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .run  (mode_q == FN_DELAY),
        .tick (cell_in[0]),
        .din  (cell_in[1]),
        .sel  (edge_sel_e'(cfg_edge)),
        .limit(cfg_val),
        .dout (dly_y)
    );

    always_comb begin
        case (mode_q)
            FN_COUNT: cell_out = cnt_y;
            FN_DELAY: cell_out = dly_y;
            default:  cell_out = lut_y;
        endcase
    end
endmodule

// File: rtl/cell_checker.sv
module cell_checker
    import cell_pkg::*;
#(
    parameter int LUT_K = 4,
    localparam int ROWS = 2 ** LUT_K
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       cfg_edge,
    input logic [ROWS-1:0]  cfg_lut,
    input logic [LUT_K-1:0] cell_in,
    input logic             cell_out,
    input cell_fn_e         mode_q
);
    // R1: table lookup at the ports
    assert_lut_row_R1: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FN_LUT) |-> (cell_out == cfg_lut[cell_in]));

    // R3: function is frozen outside reset
    assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    // R5: rising clear input gives a pulse
    assert_clear_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FN_COUNT && cell_in[1] && !$past(cell_in[1])) |=> cell_out);

    // R5: clear held high gives no pulse
    assert_clear_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FN_COUNT && cell_in[1] && $past(cell_in[1]) && !$past(rst)) |=> !cell_out);

    // R8: unselected edge passes on the next tick
    assert_pass_edge_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FN_DELAY && cell_in[0] && (cell_in[1] != cell_out)
         && !edge_held(edge_sel_e'(cfg_edge), cell_in[1]))
        |=> (cell_out == $past(cell_in[1])));

    // R9: no tick, no output change
    assert_tick_gated_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == FN_DELAY && !cell_in[0]) |=> $stable(cell_out));
endmodule

bind lut_cnt_cell cell_checker #(.LUT_K(LUT_K)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .cfg_edge(cfg_edge),
    .cfg_lut (cfg_lut),
    .cell_in (cell_in),
    .cell_out(cell_out),
    .mode_q  (mode_q)
);

// File: tb/sim_lut_cnt_cell.sv
module sim_lut_cnt_cell;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_func = 2'b00;
    logic [1:0]  cfg_edge = 2'b11;
    logic [7:0]  cfg_val = 8'd0;
    logic [15:0] cfg_lut = 16'h0000;
    logic [3:0]  cell_in = 4'h0;
    logic        cell_out;

    int total = 0;
    int bad = 0;

    lut_cnt_cell u0 (
        .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_edge(cfg_edge),
        .cfg_val(cfg_val), .cfg_lut(cfg_lut), .cell_in(cell_in), .cell_out(cell_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // {table word, input index, expected output}
    localparam logic [20:0] LUT_VEC [15] = '{
        {16'h8000, 4'hF, 1'b1}, {16'h8000, 4'hE, 1'b0},
        {16'hFFFE, 4'h0, 1'b0}, {16'hFFFE, 4'h4, 1'b1},
        {16'h6996, 4'h1, 1'b1}, {16'h6996, 4'h7, 1'b1},
        {16'h6996, 4'h3, 1'b0}, {16'h7FFF, 4'hF, 1'b0},
        {16'h7FFF, 4'h0, 1'b1}, {16'h0001, 4'h0, 1'b1},
        {16'h0001, 4'h8, 1'b0}, {16'h9669, 4'h3, 1'b1},
        {16'h9669, 4'h2, 1'b0}, {16'h5555, 4'hA, 1'b1},
        {16'hA5C3, 4'h9, 1'b0}
    };

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive tick/control right after a falling edge; return after the next one.
    task automatic cyc(input logic t, input logic c);
        cell_in[0] = t;
        cell_in[1] = c;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] fn);
        rst = 1'b1;
        cfg_func = fn;
        cell_in = 4'h0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 / R2: table walk
        do_reset(2'b00);
        foreach (LUT_VEC[i]) begin
            cfg_lut = LUT_VEC[i][20:5];
            cell_in = LUT_VEC[i][4:1];
            #1;
            chk("R2 table vector", cell_out, LUT_VEC[i][0]);
        end
        // R1: combinational response, no clock edge in between
        cfg_lut = 16'h5555;
        cell_in = 4'h1;
        #1 chk("R1 inverter in0=1", cell_out, 1'b0);
        cell_in = 4'h0;
        #1 chk("R1 inverter in0=0", cell_out, 1'b1);
        @(negedge clk);

        // R10: counter mode reset state
        cfg_val = 8'd3;
        rst = 1'b1;
        cfg_func = 2'b01;
        cell_in = 4'h0;
        @(negedge clk);
        @(negedge clk);
        chk("R10 out during reset", cell_out, 1'b0);
        rst = 1'b0;
        cyc(0, 0);
        chk("R10 out after reset", cell_out, 1'b0);

        // R4: limit 3, pulse after every 4th tick
        for (int k = 1; k <= 12; k++) begin
            cyc(1, 0);
            chk("R4 period", cell_out, (k % 4) == 0);
        end
        cyc(0, 0);
        chk("R4 idle cycle", cell_out, 1'b0);
        cyc(1, 0);
        chk("R4 tick1", cell_out, 1'b0);
        cyc(0, 0);
        cyc(1, 0);
        chk("R4 tick2 after gap", cell_out, 1'b0);

        // R5: clear rising edge, hold, then restart from zero
        cyc(0, 1);
        chk("R5 clear rise pulse", cell_out, 1'b1);
        cyc(1, 1);
        chk("R5 clear held", cell_out, 1'b0);
        cyc(1, 1);
        chk("R5 clear held tick", cell_out, 1'b0);
        cyc(0, 0);
        chk("R5 clear release", cell_out, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            cyc(1, 0);
            chk("R5 count restarts", cell_out, k == 4);
        end

        // R4: limit 0, pulse on every tick
        cfg_val = 8'd0;
        for (int k = 0; k < 3; k++) begin
            cyc(1, 0);
            chk("R4 limit zero", cell_out, 1'b1);
        end
        cyc(0, 0);
        chk("R4 limit zero idle", cell_out, 1'b0);

        // R3: function code ignored outside reset
        cfg_func = 2'b00;
        cfg_lut = 16'hFFFF;
        cyc(0, 0);
        chk("R3 code change ignored", cell_out, 1'b0);
        do_reset(2'b11);
        #1 chk("R3 code 11 selects table", cell_out, 1'b1);
        @(negedge clk);

        // R6: delay mode, both edges, limit 2
        cfg_val = 8'd2;
        cfg_edge = 2'b11;
        do_reset(2'b10);
        chk("R10 delay reset", cell_out, 1'b0);
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 1);
            chk("R6 rise delay", cell_out, k == 3);
        end
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 0);
            chk("R6 fall delay", cell_out, k != 3);
        end

        // R9: no ticks, no progress
        for (int k = 0; k < 4; k++) begin
            cyc(0, 1);
            chk("R9 no tick", cell_out, 1'b0);
        end
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 1);
            chk("R9 ticks only count", cell_out, k == 3);
        end

        // R7: cancelled fall, then fresh delay
        cyc(1, 0);
        cyc(1, 0);
        chk("R7 pending", cell_out, 1'b1);
        cyc(1, 1);
        chk("R7 cancelled", cell_out, 1'b1);
        cyc(1, 1);
        cyc(1, 1);
        chk("R7 stays", cell_out, 1'b1);
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 0);
            chk("R7 fresh delay", cell_out, k != 3);
        end

        // R8: edge select variants
        cfg_edge = 2'b01;
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 1);
            chk("R8 rise-only rise", cell_out, k == 3);
        end
        cyc(1, 0);
        chk("R8 rise-only fall passes", cell_out, 1'b0);
        cfg_edge = 2'b10;
        cyc(1, 1);
        chk("R8 fall-only rise passes", cell_out, 1'b1);
        for (int k = 1; k <= 3; k++) begin
            cyc(1, 0);
            chk("R8 fall-only fall", cell_out, k != 3);
        end
        cfg_edge = 2'b00;
        cyc(1, 1);
        chk("R8 none rise", cell_out, 1'b1);
        cyc(1, 0);
        chk("R8 none fall", cell_out, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule